// File: doc/BRIEF.md
# Accumulator Group ALU

This block runs the single-word accumulator operations of a small 4-bit processor. It holds a 4-bit accumulator and a carry flag. Each cycle in which `in_valid` is high, it applies one operation to these two registers. The operation is picked by a 4-bit major code `in_op` and, for the 1111 major code, by a 4-bit minor code `in_sub`. The caller supplies the register value read from the index file on `in_reg` and the immediate nibble on `in_imm`.

The exchange operation returns the old accumulator value to the caller on a registered writeback port, and the caller writes it into its register file. The block does not contain the register file. Arithmetic runs in binary, and a decimal adjust step corrects binary sums into packed decimal digits. For subtraction the carry flag holds the inverse of the borrow.

Top module: `acc_group_alu`

## Requirements
- R1: While `rst` is high at a rising edge, the next state is accumulator 0, carry 0 and `wb_valid` 0.
- R2: In a cycle with `in_valid` low, accumulator and carry keep their values. The same holds with `in_valid` high for a major code outside {1000, 1001, 1010, 1011, 1101, 1111}, or for major code 1111 with minor code 1101, 1110 or 1111.
- R3: Major code 1000 sets acc = acc + reg + carry, keeping the low 4 bits. Carry becomes bit 4 of the sum.
- R4: Major code 1001 computes acc + (~reg) + carry. The low 4 bits go to acc and bit 4 goes to carry. Carry is therefore 1 when no borrow occurs, and a carry of 0 on entry takes one extra unit.
- R5: Major code 1010 loads `in_reg` into acc. Major code 1101 loads `in_imm` into acc. Carry is unchanged by both.
- R6: Major code 1011 loads `in_reg` into acc, leaves carry unchanged, and on the next cycle raises `wb_valid` for exactly one cycle with `wb_data` equal to the old acc.
- R7: Under major code 1111, minor code 0000 clears acc and carry, 0001 clears carry only, 1010 sets carry, and 0011 inverts carry.
- R8: Under major code 1111, minor code 0010 adds 1 to acc and sets carry to the carry out. Minor code 1000 subtracts 1 from acc and sets carry to 1 when acc was nonzero, 0 otherwise. Minor code 0100 inverts every bit of acc.
- R9: Under major code 1111, minor code 0101 rotates the 5-bit value {carry, acc} left, so the old carry enters acc bit 0 and acc bit 3 enters carry. Minor code 0110 rotates it right, so the old carry enters acc bit 3 and acc bit 0 enters carry.
- R10: Under major code 1111, minor code 0111 sets acc to the old carry (0 or 1) and clears carry. Minor code 1001 sets acc to 10 if carry was 1, else 9, and clears carry.
- R11: Under major code 1111, minor code 1011 adds 6 to acc when acc > 9 or carry is 1. Carry is then set if that addition overflows 4 bits, and otherwise left as it was. In every other case acc and carry are unchanged.
- R12: Under major code 1111, minor code 1100 maps acc 0, 1, 2, 4, 8 to 0, 1, 2, 3, 4 and any other value to 15. Carry is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Execute the operation presented this cycle |
| in_op | input | 4 | Major operation code |
| in_sub | input | 4 | Minor operation code, used with major code 1111 |
| in_reg | input | 4 | Index register value read by the caller |
| in_imm | input | 4 | Immediate nibble for the load-immediate operation |
| acc | output | 4 | Accumulator, registered |
| carry | output | 1 | Carry flag, registered |
| wb_valid | output | 1 | One-cycle strobe after an exchange |
| wb_data | output | 4 | Old accumulator value for the register file |

## Verification
The hardest cases to reach are the ones that depend on accumulator and carry values built up by earlier operations. These include decimal adjust with carry already set and no new overflow, the decrement wrap from zero, and a carry-in of 0 in subtraction. No port loads state directly. The stimulus is therefore one long chain of operations where each result sets up the next corner: an add that overflows feeds a subtract with carry 1, and a decimal adjust that overflows is followed by one that only adds 6 under the old carry.

// File: rtl/accg_pkg.sv
package accg_pkg;
  localparam int NIB = 4;

  // major codes
  localparam logic [3:0] OP_ADD = 4'b1000;
  localparam logic [3:0] OP_SUB = 4'b1001;
  localparam logic [3:0] OP_LDR = 4'b1010;
  localparam logic [3:0] OP_XCH = 4'b1011;
  localparam logic [3:0] OP_LDI = 4'b1101;
  localparam logic [3:0] OP_GRP = 4'b1111;

  // minor codes under OP_GRP
  localparam logic [3:0] G_CLRB = 4'h0;
  localparam logic [3:0] G_CLRC = 4'h1;
  localparam logic [3:0] G_INC  = 4'h2;
  localparam logic [3:0] G_CMC  = 4'h3;
  localparam logic [3:0] G_CMA  = 4'h4;
  localparam logic [3:0] G_ROL  = 4'h5;
  localparam logic [3:0] G_ROR  = 4'h6;
  localparam logic [3:0] G_C2A  = 4'h7;
  localparam logic [3:0] G_DEC  = 4'h8;
  localparam logic [3:0] G_SCV  = 4'h9;
  localparam logic [3:0] G_SETC = 4'hA;
  localparam logic [3:0] G_DADJ = 4'hB;
  localparam logic [3:0] G_KEY  = 4'hC;
endpackage

// File: rtl/accg_addsub.sv
module accg_addsub #(
  parameter int W = 4
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         inv_b,
  input  logic         cin,
  output logic [W-1:0] sum,
  output logic         cout
);
  logic [W-1:0] b_eff;
  logic [W:0]   full;

  assign b_eff = inv_b ? ~b : b;
  assign full  = {1'b0, a} + {1'b0, b_eff} + {{W{1'b0}}, cin};
  assign sum   = full[W-1:0];
  assign cout  = full[W];
endmodule

// File: rtl/accg_keycode.sv
module accg_keycode #(
  parameter int W = 4
) (
  input  logic [W-1:0] val,
  output logic [W-1:0] code
);
  always_comb begin
    code = '1;
    if (val == '0) code = '0;
    for (int i = 0; i < W; i++) begin
      if (val == W'(1 << i)) code = W'(i + 1);
    end
  end
endmodule

// File: rtl/acc_group_alu.sv
module acc_group_alu
  import accg_pkg::*;
#(
  parameter int W = NIB
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_valid,
  input  logic [3:0]   in_op,
  input  logic [3:0]   in_sub,
  input  logic [W-1:0] in_reg,
  input  logic [W-1:0] in_imm,
  output logic [W-1:0] acc,
  output logic         carry,
  output logic         wb_valid,
  output logic [W-1:0] wb_data
);
  localparam logic [W-1:0] DEC_MAX = W'(9);
  localparam logic [W-1:0] DEC_FIX = W'(6);
  localparam logic [W-1:0] SCV_HI  = W'(10);
  localparam logic [W-1:0] SCV_LO  = W'(9);

  logic [W-1:0] acc_q, acc_n;
  logic         cy_q, cy_n;
  logic         wb_q, wb_n;
  logic [W-1:0] wbd_q;

  // shared adder operands
  logic [W-1:0] add_b, add_sum;
  logic         add_inv, add_cin, add_cout;
  logic [W-1:0] key_code;

  accg_addsub #(.W(W)) u_add (
    .a(acc_q), .b(add_b), .inv_b(add_inv), .cin(add_cin),
    .sum(add_sum), .cout(add_cout)
  );

  accg_keycode #(.W(W)) u_key (
    .val(acc_q), .code(key_code)
  );

  always_comb begin
    add_b   = in_reg;
    add_inv = 1'b0;
    add_cin = cy_q;
    if (in_op == OP_SUB) begin
      add_inv = 1'b1;
    end else if (in_op == OP_GRP) begin
      unique case (in_sub)
        G_INC:   begin add_b = '0;      add_inv = 1'b0; add_cin = 1'b1; end
        G_DEC:   begin add_b = W'(1);   add_inv = 1'b1; add_cin = 1'b1; end
        default: begin add_b = DEC_FIX; add_inv = 1'b0; add_cin = 1'b0; end
      endcase
    end
  end

  always_comb begin
    acc_n = acc_q;
    cy_n  = cy_q;
    wb_n  = 1'b0;
    if (in_valid) begin
      case (in_op)
        OP_ADD, OP_SUB: begin acc_n = add_sum; cy_n = add_cout; end
        OP_LDR:         acc_n = in_reg;
        OP_XCH:         begin acc_n = in_reg; wb_n = 1'b1; end
        OP_LDI:         acc_n = in_imm;
        OP_GRP: begin
          case (in_sub)
            G_CLRB: begin acc_n = '0; cy_n = 1'b0; end
            G_CLRC: cy_n = 1'b0;
            G_INC, G_DEC: begin acc_n = add_sum; cy_n = add_cout; end
            G_CMC:  cy_n = ~cy_q;
            G_CMA:  acc_n = ~acc_q;
            G_ROL:  {cy_n, acc_n} = {acc_q, cy_q};
            G_ROR:  {acc_n, cy_n} = {cy_q, acc_q};
            G_C2A:  begin acc_n = {{(W-1){1'b0}}, cy_q}; cy_n = 1'b0; end
            G_SCV:  begin acc_n = cy_q ? SCV_HI : SCV_LO; cy_n = 1'b0; end
            G_SETC: cy_n = 1'b1;
            G_DADJ: begin
              if (acc_q > DEC_MAX || cy_q) begin
                acc_n = add_sum;
                if (add_cout) cy_n = 1'b1;
              end
            end
            G_KEY:  acc_n = key_code;
            default: ;
          endcase
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q <= '0;
      cy_q  <= 1'b0;
      wb_q  <= 1'b0;
      wbd_q <= '0;
    end else begin
      acc_q <= acc_n;
      cy_q  <= cy_n;
      wb_q  <= wb_n;
      if (wb_n) wbd_q <= acc_q;
    end
  end

  assign acc      = acc_q;
  assign carry    = cy_q;
  assign wb_valid = wb_q;
  assign wb_data  = wbd_q;
endmodule

// File: rtl/acc_group_alu_chk.sv
module acc_group_alu_chk
  import accg_pkg::*;
#(
  parameter int W = NIB
) (
  input logic         clk,
  input logic         rst,
  input logic         in_valid,
  input logic [3:0]   in_op,
  input logic [3:0]   in_sub,
  input logic [W-1:0] in_reg,
  input logic [W-1:0] in_imm,
  input logic [W-1:0] acc,
  input logic         carry,
  input logic         wb_valid,
  input logic [W-1:0] wb_data
);
  a_r1_reset_clear: assert property (@(posedge clk)
    rst |=> (acc == '0 && !carry && !wb_valid));

  a_r2_idle_hold: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> ($stable(acc) && $stable(carry)));

  a_r5_imm_load: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_op == OP_LDI) |=> (acc == $past(in_imm) && carry == $past(carry)));

  a_r6_xch_result: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_op == OP_XCH) |=> (wb_valid && wb_data == $past(acc) && acc == $past(in_reg)));

  a_r6_wb_cause: assert property (@(posedge clk) disable iff (rst)
    wb_valid |-> ($past(in_valid) && $past(in_op) == OP_XCH));

  a_r7_set_carry: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_op == OP_GRP && in_sub == G_SETC) |=> carry);

  a_r9_rotate_left: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_op == OP_GRP && in_sub == G_ROL) |=>
      (acc == {$past(acc[W-2:0]), $past(carry)} && carry == $past(acc[W-1])));

  a_r12_key_range: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_op == OP_GRP && in_sub == G_KEY) |=> (acc <= W'(W) || acc == '1));
endmodule

bind acc_group_alu acc_group_alu_chk #(.W(W)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_op(in_op), .in_sub(in_sub),
  .in_reg(in_reg), .in_imm(in_imm), .acc(acc), .carry(carry),
  .wb_valid(wb_valid), .wb_data(wb_data)
);

// File: tb/sim_acc_group_alu.sv
module sim_acc_group_alu;
  logic       clk = 1'b0;
  logic       rst;
  logic       in_valid;
  logic [3:0] in_op, in_sub, in_reg, in_imm;
  logic [3:0] acc, wb_data;
  logic       carry, wb_valid;

  int errors = 0;
  int checks = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  acc_group_alu u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_op(in_op), .in_sub(in_sub),
    .in_reg(in_reg), .in_imm(in_imm), .acc(acc), .carry(carry),
    .wb_valid(wb_valid), .wb_data(wb_data)
  );

  // {tag, op, sub, reg, imm, expected acc, expected carry}
  localparam int NV = 32;
  localparam logic [24:0] VEC [NV] = '{
    {4'd5,  4'hD, 4'h0, 4'h0, 4'h7, 4'h7, 1'b0}, // R5 load imm 7
    {4'd3,  4'h8, 4'h0, 4'h5, 4'h0, 4'hC, 1'b0}, // R3 7+5
    {4'd3,  4'h8, 4'h0, 4'h6, 4'h0, 4'h2, 1'b1}, // R3 overflow
    {4'd3,  4'h8, 4'h0, 4'h3, 4'h0, 4'h6, 1'b0}, // R3 carry in
    {4'd4,  4'h9, 4'h0, 4'h2, 4'h0, 4'h3, 1'b1}, // R4 carry 0 on entry
    {4'd4,  4'h9, 4'h0, 4'h5, 4'h0, 4'hE, 1'b0}, // R4 borrow
    {4'd7,  4'hF, 4'hA, 4'h0, 4'h0, 4'hE, 1'b1}, // R7 set carry
    {4'd7,  4'hF, 4'h3, 4'h0, 4'h0, 4'hE, 1'b0}, // R7 invert carry
    {4'd8,  4'hF, 4'h4, 4'h0, 4'h0, 4'h1, 1'b0}, // R8 invert acc
    {4'd9,  4'hF, 4'h5, 4'h0, 4'h0, 4'h2, 1'b0}, // R9 rotate left
    {4'd7,  4'hF, 4'hA, 4'h0, 4'h0, 4'h2, 1'b1}, // R7 set carry
    {4'd9,  4'hF, 4'h5, 4'h0, 4'h0, 4'h5, 1'b0}, // R9 rotate left carry in
    {4'd9,  4'hF, 4'h6, 4'h0, 4'h0, 4'h2, 1'b1}, // R9 rotate right
    {4'd10, 4'hF, 4'h7, 4'h0, 4'h0, 4'h1, 1'b0}, // R10 carry to acc
    {4'd8,  4'hF, 4'h8, 4'h0, 4'h0, 4'h0, 1'b1}, // R8 dec no borrow
    {4'd8,  4'hF, 4'h8, 4'h0, 4'h0, 4'hF, 1'b0}, // R8 dec wraps
    {4'd8,  4'hF, 4'h2, 4'h0, 4'h0, 4'h0, 1'b1}, // R8 inc wraps
    {4'd10, 4'hF, 4'h9, 4'h0, 4'h0, 4'hA, 1'b0}, // R10 carry 1 gives 10
    {4'd10, 4'hF, 4'h9, 4'h0, 4'h0, 4'h9, 1'b0}, // R10 carry 0 gives 9
    {4'd7,  4'hF, 4'h0, 4'h0, 4'h0, 4'h0, 1'b0}, // R7 clear both
    {4'd5,  4'hD, 4'h0, 4'h0, 4'hC, 4'hC, 1'b0}, // R5 load imm 12
    {4'd11, 4'hF, 4'hB, 4'h0, 4'h0, 4'h2, 1'b1}, // R11 over 9, overflow
    {4'd11, 4'hF, 4'hB, 4'h0, 4'h0, 4'h8, 1'b1}, // R11 carry only, keeps carry
    {4'd7,  4'hF, 4'h1, 4'h0, 4'h0, 4'h8, 1'b0}, // R7 clear carry
    {4'd11, 4'hF, 4'hB, 4'h0, 4'h0, 4'h8, 1'b0}, // R11 no adjust
    {4'd12, 4'hF, 4'hC, 4'h0, 4'h0, 4'h4, 1'b0}, // R12 8 -> 4
    {4'd5,  4'hD, 4'h0, 4'h0, 4'h3, 4'h3, 1'b0}, // R5 load imm 3
    {4'd12, 4'hF, 4'hC, 4'h0, 4'h0, 4'hF, 1'b0}, // R12 not one-hot
    {4'd12, 4'hF, 4'hC, 4'h0, 4'h0, 4'hF, 1'b0}, // R12 15 -> 15
    {4'd5,  4'hA, 4'h0, 4'h9, 4'h0, 4'h9, 1'b0}, // R5 load reg
    {4'd2,  4'h0, 4'h0, 4'h3, 4'h4, 4'h9, 1'b0}, // R2 unassigned major
    {4'd2,  4'hF, 4'hD, 4'h3, 4'h4, 4'h9, 1'b0}  // R2 unassigned minor
  };

  task automatic check(input string req, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, got, exp);
    end
  endtask

  // called at a falling edge; returns at the falling edge after the update
  task automatic do_op(input logic [3:0] op, input logic [3:0] sub,
                       input logic [3:0] r, input logic [3:0] imm);
    in_op = op; in_sub = sub; in_reg = r; in_imm = imm; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    in_valid = 1'b0; in_op = '0; in_sub = '0; in_reg = '0; in_imm = '0;
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    check("R1 acc", acc, 0);
    check("R1 carry", carry, 0);
    check("R1 wb_valid", wb_valid, 0);

    for (int i = 0; i < NV; i++) begin
      do_op(VEC[i][20:17], VEC[i][16:13], VEC[i][12:9], VEC[i][8:5]);
      check($sformatf("R%0d vec %0d acc", VEC[i][24:21], i), acc, VEC[i][4:1]);
      check($sformatf("R%0d vec %0d carry", VEC[i][24:21], i), carry, VEC[i][0]);
    end

    // R2 valid low: a load-immediate presented without strobe
    in_op = 4'hD; in_imm = 4'h2; in_valid = 1'b0;
    @(negedge clk);
    check("R2 idle acc", acc, 9);

    // R6 exchange: acc 9, reg 4
    do_op(4'hB, 4'h0, 4'h4, 4'h0);
    check("R6 acc", acc, 4);
    check("R6 wb_valid", wb_valid, 1);
    check("R6 wb_data", wb_data, 9);
    @(negedge clk);
    check("R6 wb_valid drop", wb_valid, 0);

    // R1 reset during operation
    do_op(4'hF, 4'hA, 4'h0, 4'h0);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check("R1 rerun acc", acc, 0);
    check("R1 rerun carry", carry, 0);

    finish_run();
  end

  initial begin
    repeat (100000) @(negedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      finish_run();
    end
  end
endmodule